// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block turns a decoded memory-operand descriptor into a physical address. It takes the two-bit addressing mode, the three-bit register/memory selector, an optional displacement, the current base and index register values and four segment register values. From these it forms a 16-bit effective offset and picks a segment: either the default implied by the addressing form or an explicit override. The segment value is shifted left by four bit positions and the offset is added to it, which gives a 20-bit physical address.

A separate port mode bypasses segmentation. The 16-bit port number goes straight to the low bits of the address, and the upper four bits are zero. When the mode field selects a register operand, no address is formed and a flag is raised instead. Inputs are taken on a valid strobe, and the result appears registered one clock later. Parsing of instruction bytes and the bus interface belong to neighbouring blocks.

Top module: `opaddr_gen`

## Requirements
- R1: During and directly after reset, `out_valid`, `reg_operand`, `phys_addr` and `out_offset` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `phys_addr`, `out_offset` and `reg_operand` keep their values.
- R3: With `io_mode` low and `mode` = 11, `reg_operand` is 1 and `phys_addr` and `out_offset` are zero.
- R4: The `rm` code selects the offset sum. The codes are: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. The displacement is added to the selected sum.
- R5: The `mode` code selects the displacement. Code 00 adds nothing. Code 01 adds `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` has no effect. Code 10 adds all 16 bits of `disp`.
- R6: With `mode` = 00 and `rm` = 110, the offset is `disp` itself and no register is used.
- R7: Without an override, the segment is SS for `rm` 010 and 011, and for `rm` 110 when `mode` is 01 or 10. Every other memory form uses DS.
- R8: With `ovr_en` high, `ovr_sel` picks the segment and replaces the default. The codes are: 00 ES, 01 CS, 10 SS, 11 DS.
- R9: `phys_addr` = (segment × 16 + offset) mod 2^20, and the offset wraps modulo 2^16.
- R10: With `io_mode` high, `phys_addr` = {4'b0, `port_num`}, `out_offset` = `port_num` and `reg_operand` = 0. This holds whatever the values of `mode`, `rm` and the override inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the operand descriptor |
| io_mode | input | 1 | Port-address request |
| mode | input | 2 | Addressing mode code |
| rm | input | 3 | Register/memory selector |
| disp | input | 16 | Displacement |
| bx_val | input | 16 | BX value |
| bp_val | input | 16 | BP value |
| si_val | input | 16 | SI value |
| di_val | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| port_num | input | 16 | Port number for port mode |
| out_valid | output | 1 | Result valid |
| phys_addr | output | 20 | Physical address |
| out_offset | output | 16 | Effective offset |
| reg_operand | output | 1 | Operand is a register, no address formed |

## Verification
The directed cases cover the following corners, each with the failure it would expose:
- A short displacement with a negative low byte and unrelated junk in the upper byte. A design that zero-extends would yield an offset 256 too large, and one that uses the full field would pick up the junk.
- The direct-address form. A design that treats it as BP-based would add BP and default to SS.
- Offsets that overflow 16 bits. A design with a 17-bit offset would carry into the segment part.
- A maximal segment with a maximal offset. This checks the 20-bit wrap, which a wider adder would overshoot.
- Port mode with a register-mode code and an active override present. A design that let either one win over port mode would show it in the upper nibble or the flag.

Random operands, checked against a bench model, cover the rest of the offset table and the segment choice.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
   typedef enum logic [1:0] {
      SEG_ES = 2'b00,
      SEG_CS = 2'b01,
      SEG_SS = 2'b10,
      SEG_DS = 2'b11
   } seg_id_e;

   typedef enum logic [1:0] {
      MOD_NODISP = 2'b00,
      MOD_DISP8  = 2'b01,
      MOD_DISP16 = 2'b10,
      MOD_REG    = 2'b11
   } mod_e;

   localparam int unsigned NUM_SEGS = 4;
endpackage

// File: rtl/oa_offset.sv
module oa_offset #(
   parameter int unsigned OFS_W   = 16,
   parameter int unsigned SHORT_W = 8
) (
   input  logic [1:0]       mode,
   input  logic [2:0]       rm,
   input  logic [OFS_W-1:0] disp,
   input  logic [OFS_W-1:0] bx_val,
   input  logic [OFS_W-1:0] bp_val,
   input  logic [OFS_W-1:0] si_val,
   input  logic [OFS_W-1:0] di_val,
   output logic [OFS_W-1:0] offset,
   output logic             uses_bp
);
   import opaddr_pkg::*;
   localparam int unsigned EXT_W = OFS_W - SHORT_W;

   logic [OFS_W-1:0] base_v, idx_v, disp_x;
   logic             direct;

   always_comb begin
      case (mode)
         MOD_DISP8:  disp_x = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
         MOD_DISP16: disp_x = disp;
         default:    disp_x = '0;
      endcase
   end

   always_comb begin
      base_v  = '0;
      idx_v   = '0;
      uses_bp = 1'b0;
      case (rm)
         3'd0: begin base_v = bx_val; idx_v = si_val; end
         3'd1: begin base_v = bx_val; idx_v = di_val; end
         3'd2: begin base_v = bp_val; idx_v = si_val; uses_bp = 1'b1; end
         3'd3: begin base_v = bp_val; idx_v = di_val; uses_bp = 1'b1; end
         3'd4: idx_v = si_val;
         3'd5: idx_v = di_val;
         3'd6: begin base_v = bp_val; uses_bp = 1'b1; end
         default: base_v = bx_val;
      endcase
      direct = (mode == MOD_NODISP) && (rm == 3'd6);
      if (direct) begin
         uses_bp = 1'b0;
         offset  = disp;
      end else begin
         offset  = base_v + idx_v + disp_x;
      end
   end
endmodule

// File: rtl/oa_segsel.sv
module oa_segsel #(
   parameter int unsigned SEG_W = 16
) (
   input  logic [3:0][SEG_W-1:0] segs,
   input  logic                  uses_bp,
   input  logic                  ovr_en,
   input  logic [1:0]            ovr_sel,
   output logic [SEG_W-1:0]      seg_val
);
   import opaddr_pkg::*;

   logic [1:0]          pick;
   logic [NUM_SEGS-1:0] pick_oh;
   logic [NUM_SEGS-1:0][SEG_W-1:0] masked;

   always_comb begin
      if (ovr_en)       pick = ovr_sel;
      else if (uses_bp) pick = SEG_SS;
      else              pick = SEG_DS;
   end

   genvar g;
   generate
      for (g = 0; g < NUM_SEGS; g++) begin : g_lane
         assign pick_oh[g] = (pick == g[1:0]);
         assign masked[g]  = pick_oh[g] ? segs[g] : '0;
      end
   endgenerate

   always_comb begin
      seg_val = '0;
      for (int i = 0; i < NUM_SEGS; i++) seg_val = seg_val | masked[i];
   end
endmodule

// File: rtl/oa_phys.sv
module oa_phys #(
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   localparam int unsigned PA_W     = OFS_W + SEG_SHIFT
) (
   input  logic [OFS_W-1:0] seg_val,
   input  logic [OFS_W-1:0] offset,
   output logic [PA_W-1:0]  phys
);
   logic [PA_W-1:0] seg_sh, ofs_z;
   assign seg_sh = {seg_val, {SEG_SHIFT{1'b0}}};
   assign ofs_z  = PA_W'(offset);
   assign phys   = seg_sh + ofs_z;
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SHORT_W   = 8,
   parameter int unsigned SEG_SHIFT = 4,
   localparam int unsigned PA_W     = OFS_W + SEG_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             io_mode,
   input  logic [1:0]       mode,
   input  logic [2:0]       rm,
   input  logic [OFS_W-1:0] disp,
   input  logic [OFS_W-1:0] bx_val,
   input  logic [OFS_W-1:0] bp_val,
   input  logic [OFS_W-1:0] si_val,
   input  logic [OFS_W-1:0] di_val,
   input  logic [OFS_W-1:0] seg_es,
   input  logic [OFS_W-1:0] seg_cs,
   input  logic [OFS_W-1:0] seg_ss,
   input  logic [OFS_W-1:0] seg_ds,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_sel,
   input  logic [OFS_W-1:0] port_num,
   output logic             out_valid,
   output logic [PA_W-1:0]  phys_addr,
   output logic [OFS_W-1:0] out_offset,
   output logic             reg_operand
);
   import opaddr_pkg::*;

   generate
      if (SHORT_W < 1 || SHORT_W >= OFS_W) begin : g_bad_short
         $error("SHORT_W must lie between 1 and OFS_W-1");
      end
      if (SEG_SHIFT < 1) begin : g_bad_shift
         $error("SEG_SHIFT must be at least 1");
      end
   endgenerate

   logic [3:0][OFS_W-1:0] segs;
   logic [OFS_W-1:0]      ofs_c, seg_c;
   logic [PA_W-1:0]       phys_c, phys_n;
   logic [OFS_W-1:0]      ofs_n;
   logic                  bp_c, reg_n;

   assign segs[SEG_ES] = seg_es;
   assign segs[SEG_CS] = seg_cs;
   assign segs[SEG_SS] = seg_ss;
   assign segs[SEG_DS] = seg_ds;

   oa_offset #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ofs (
      .mode(mode), .rm(rm), .disp(disp),
      .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
      .offset(ofs_c), .uses_bp(bp_c)
   );

   oa_segsel #(.SEG_W(OFS_W)) u_seg (
      .segs(segs), .uses_bp(bp_c), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
      .seg_val(seg_c)
   );

   oa_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
      .seg_val(seg_c), .offset(ofs_c), .phys(phys_c)
   );

   always_comb begin
      if (io_mode) begin
         phys_n = PA_W'(port_num);
         ofs_n  = port_num;
         reg_n  = 1'b0;
      end else if (mode == MOD_REG) begin
         phys_n = '0;
         ofs_n  = '0;
         reg_n  = 1'b1;
      end else begin
         phys_n = phys_c;
         ofs_n  = ofs_c;
         reg_n  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         phys_addr   <= '0;
         out_offset  <= '0;
         reg_operand <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            phys_addr   <= phys_n;
            out_offset  <= ofs_n;
            reg_operand <= reg_n;
         end
      end
   end
endmodule

// File: rtl/oa_checker.sv
module oa_checker #(
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   localparam int unsigned PA_W     = OFS_W + SEG_SHIFT
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             io_mode,
   input logic [1:0]       mode,
   input logic [OFS_W-1:0] port_num,
   input logic             out_valid,
   input logic [PA_W-1:0]  phys_addr,
   input logic [OFS_W-1:0] out_offset,
   input logic             reg_operand
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(phys_addr) && $stable(out_offset) && $stable(reg_operand)); // R2
   AST_REG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !io_mode && mode == 2'b11 |=> reg_operand); // R3
   AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && reg_operand |-> phys_addr == '0); // R3
   AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !io_mode && mode != 2'b11 |=> phys_addr[SEG_SHIFT-1:0] == out_offset[SEG_SHIFT-1:0]); // R9
   AST_PORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && io_mode |=> !reg_operand && phys_addr == PA_W'($past(port_num))); // R10
endmodule

bind opaddr_gen oa_checker #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (.*);

// File: tb/tb_opaddr_gen.sv
`timescale 1ns/1ps
module tb_opaddr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, io_mode = 1'b0, ovr_en = 1'b0;
   logic [1:0]  mode = '0, ovr_sel = '0;
   logic [2:0]  rm = '0;
   logic [15:0] disp = '0, bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
   logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0, port_num = '0;
   logic        out_valid, reg_operand;
   logic [19:0] phys_addr;
   logic [15:0] out_offset;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   opaddr_gen dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] f_off(logic [1:0] m, logic [2:0] r, logic [15:0] d,
         logic [15:0] b, logic [15:0] p, logic [15:0] s, logic [15:0] i);
      logic [15:0] dx, sum;
      if (m == 2'b00 && r == 3'd6) return d;
      dx = (m == 2'b01) ? {{8{d[7]}}, d[7:0]} : (m == 2'b10) ? d : 16'h0;
      case (r)
         3'd0: sum = b + s;  3'd1: sum = b + i;
         3'd2: sum = p + s;  3'd3: sum = p + i;
         3'd4: sum = s;      3'd5: sum = i;
         3'd6: sum = p;      default: sum = b;
      endcase
      return sum + dx;
   endfunction

   function automatic logic [15:0] f_seg(logic [1:0] m, logic [2:0] r, logic oe, logic [1:0] os);
      logic [1:0] id;
      if (oe) id = os;
      else if (r == 3'd2 || r == 3'd3 || (r == 3'd6 && m != 2'b00)) id = 2'b10;
      else id = 2'b11;
      case (id)
         2'b00: return seg_es; 2'b01: return seg_cs;
         2'b10: return seg_ss; default: return seg_ds;
      endcase
   endfunction

   // Apply one operand, then compare at the negedge after the capturing edge.
   task automatic op(input string tag, input logic io, input logic [1:0] m, input logic [2:0] r,
                     input logic [15:0] d, input logic oe, input logic [1:0] os);
      logic [15:0] eo;
      logic [19:0] ep;
      logic        er;
      @(negedge clk);
      io_mode = io; mode = m; rm = r; disp = d; ovr_en = oe; ovr_sel = os; in_valid = 1'b1;
      if (io) begin
         eo = port_num; ep = {4'h0, port_num}; er = 1'b0;
      end else if (m == 2'b11) begin
         eo = 16'h0; ep = 20'h0; er = 1'b1;
      end else begin
         eo = f_off(m, r, d, bx_val, bp_val, si_val, di_val);
         ep = {f_seg(m, r, oe, os), 4'h0} + {4'h0, eo};
         er = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " R2 valid"}, 32'(out_valid), 32'd1);
      chk({tag, " offset"}, 32'(out_offset), 32'(eo));
      chk({tag, " phys"}, 32'(phys_addr), 32'(ep));
      chk({tag, " regflag"}, 32'(reg_operand), 32'(er));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [19:0] hold_p;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 valid", 32'(out_valid), 0);
      chk("R1 phys", 32'(phys_addr), 0);
      chk("R1 regflag", 32'(reg_operand), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'(out_valid), 0);

      seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
      bx_val = 16'h0100; bp_val = 16'h0200; si_val = 16'h0030; di_val = 16'h0004;
      // R4: every r/m code with mode 10
      for (int r = 0; r < 8; r++) op("R4 table", 1'b0, 2'b10, 3'(r), 16'h0500, 1'b0, 2'b00);
      // R5: short displacement, negative low byte, junk high byte
      op("R5 disp8 neg", 1'b0, 2'b01, 3'd7, 16'h1280, 1'b0, 2'b00);
      op("R5 disp8 pos", 1'b0, 2'b01, 3'd4, 16'hAB7F, 1'b0, 2'b00);
      op("R5 nodisp", 1'b0, 2'b00, 3'd0, 16'hFFFF, 1'b0, 2'b00);
      // R6: direct address
      op("R6 direct", 1'b0, 2'b00, 3'd6, 16'hBEEF, 1'b0, 2'b00);
      // R7: BP base with displacement goes to SS
      op("R7 bp disp", 1'b0, 2'b01, 3'd6, 16'h0010, 1'b0, 2'b00);
      op("R7 bp si", 1'b0, 2'b00, 3'd2, 16'h0000, 1'b0, 2'b00);
      op("R7 di alone", 1'b0, 2'b00, 3'd5, 16'h0000, 1'b0, 2'b00);
      // R8: each override code
      for (int s = 0; s < 4; s++) op("R8 override", 1'b0, 2'b00, 3'd3, 16'h0, 1'b1, 2'(s));
      // R9: offset and physical wrap
      bx_val = 16'hFFFF; si_val = 16'h0002;
      op("R9 ofs wrap", 1'b0, 2'b00, 3'd0, 16'h0, 1'b0, 2'b00);
      seg_ds = 16'hFFFF;
      op("R9 phys wrap", 1'b0, 2'b10, 3'd7, 16'h0000, 1'b0, 2'b00);
      chk("R9 phys wrap literal", 32'(phys_addr), 32'h0FFEF);
      // R3: register operand
      op("R3 regmode", 1'b0, 2'b11, 3'd2, 16'h1234, 1'b1, 2'b01);
      // R10: port mode beats register mode and override
      port_num = 16'hF3A5;
      op("R10 port", 1'b1, 2'b11, 3'd6, 16'h9999, 1'b1, 2'b10);
      chk("R10 literal", 32'(phys_addr), 32'h0F3A5);
      // R2: hold while idle
      hold_p = phys_addr;
      @(negedge clk);
      port_num = 16'h0001; bx_val = 16'h7777;
      @(negedge clk);
      chk("R2 idle valid", 32'(out_valid), 0);
      chk("R2 hold", 32'(phys_addr), 32'(hold_p));

      // Random operands, R4 R5 R7 R8 R9 against the model
      for (int n = 0; n < 400; n++) begin
         bx_val = 16'($urandom); bp_val = 16'($urandom);
         si_val = 16'($urandom); di_val = 16'($urandom);
         seg_es = 16'($urandom); seg_cs = 16'($urandom);
         seg_ss = 16'($urandom); seg_ds = 16'($urandom);
         port_num = 16'($urandom);
         op("R9 random", ($urandom % 8) == 0, 2'($urandom), 3'($urandom),
            16'($urandom), 1'($urandom), 2'($urandom));
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule